// File: doc/BRIEF.md
# Dual-Channel Programmable-Ratio CIC Interpolator

This block raises the sample rate of a complex baseband stream, carried as separate in-phase and quadrature 12-bit two's-complement samples, by an integer factor chosen at run time anywhere from 2 to 63. Each channel has four comb stages clocked at the low rate, a zero-stuffing point, four integrator stages clocked at the high rate, and an output scaler. The structure's built-in low-pass response attenuates the spectral images that upsampling creates.

The block runs from one clock. A high-rate clock enable (`hi_ce`) marks each output step. A low-rate strobe (`in_valid`, counted only together with `hi_ce`) delivers a new input pair. The source raises the strobe on every R-th enabled cycle, where R is the effective ratio. On a strobe cycle the comb output enters the integrators. On the R-1 enabled cycles that follow, zeros enter instead. The integrator sum carries a DC gain of R cubed. The scaler removes this gain with a shift and a multiply that both depend on the ratio, then rounds the result and clamps it to 12 bits. Any change of the effective ratio clears the filter state.

Top module: `cic_interp`

## Requirements
- R1: While `rst` is high at a rising edge, all state clears. After that edge `out_i` and `out_q` read 0 and `out_valid` reads 0, whatever the inputs are.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `hi_ce` high. When `hi_ce` is low and the ratio does not change, `out_i` and `out_q` hold their values.
- R3: The strobe is raised on every R-th enabled cycle and both inputs are held at constant values. Each output then settles to exactly its own input value. This holds for every ratio from 2 to 63 and for inputs across the full range from -2048 to 2047.
- R4: A `ratio` value of 0 or 1 behaves exactly like a ratio of 2.
- R5: A change of the effective ratio clears all comb, integrator and output state at that edge. The outputs read 0 from the next cycle and stay 0 until a nonzero sample is strobed in. A strobe in the cycle of the change is discarded.
- R6: Feed in one positive sample followed by zero samples, with `hi_ce` held high. The output sequence is then non-negative and symmetric, and its nonzero span is between 1 and 4R-3 enabled cycles.
- R7: Feed in a positive step with `hi_ce` held high. The output never decreases and ends at the step value.
- R8: A high `in_valid` in a cycle with `hi_ce` low is ignored and injects nothing into the filter.
- R9: The two channels are independent. A nonzero input on one channel leaves the other channel's output at its own settled value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both rates |
| rst | input | 1 | Synchronous active-high reset |
| hi_ce | input | 1 | High-rate step enable; one output per enabled cycle |
| in_valid | input | 1 | Low-rate sample strobe, counted only with `hi_ce` |
| ratio | input | 6 | Interpolation ratio; 0 and 1 act as 2 |
| in_i | input | 12 | In-phase input sample, two's complement |
| in_q | input | 12 | Quadrature input sample, two's complement |
| out_i | output | 12 | In-phase output sample, rounded and clamped |
| out_q | output | 12 | Quadrature output sample, rounded and clamped |
| out_valid | output | 1 | High for one cycle after each enabled cycle |

## Verification
The bench builds the block with the package defaults: 12-bit samples, four stages on each side, a 6-bit ratio and a 14-bit scale fraction. With these values the whole ratio range is reachable, up to the largest gain of 63 cubed, where the accuracy of the scale multiply matters most for exact unity at full-scale inputs. The same values also cover the clamped ratio codes 0 and 1, so impulse, step, hold and state-clearing behaviour are all observed at ratios from 2 to 63.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int DATA_W    = 12;
    localparam int STAGES    = 4;
    localparam int RATIO_W   = 6;
    localparam int RATIO_MIN = 2;
    localparam int RATIO_MAX = 63;
    localparam int GROWTH    = STAGES * $clog2(RATIO_MAX);
    localparam int ACC_W     = DATA_W + GROWTH;
    localparam int FRAC_W    = 14;
    localparam int MULT_W    = FRAC_W + 2;
    localparam int SHIFT_W   = 6;
    localparam int NUM_CH    = 2;
    localparam int TAB_N     = 1 << RATIO_W;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;  // total right shift after the multiply
        logic [MULT_W-1:0]  mult;   // unsigned fixed-point correction factor
    } scale_t;

    function automatic int clamp_ratio(int r);
        if (r < RATIO_MIN) return RATIO_MIN;
        if (r > RATIO_MAX) return RATIO_MAX;
        return r;
    endfunction

    // DC gain of the integrator output for ratio r: r^(STAGES-1)
    function automatic longint unsigned gain_of(int r);
        longint unsigned g = 1;
        for (int k = 1; k < STAGES; k++) g = g * longint'(r);
        return g;
    endfunction

    function automatic int shift_of(int r);
        longint unsigned g = gain_of(r);
        int s = 0;
        for (int k = 0; k < 63; k++)
            if ((64'd1 << k) < g) s = k + 1;
        return s;
    endfunction

    function automatic longint unsigned mult_of(int r);
        longint unsigned g = gain_of(r);
        longint unsigned num = 64'd1 << (shift_of(r) + FRAC_W);
        return (num + g / 2) / g;
    endfunction
endpackage

// File: rtl/cic_ratio_ctrl.sv
module cic_ratio_ctrl
    import cic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clear,
    output scale_t             scl
);
    logic [RATIO_W-1:0] eff;
    logic [RATIO_W-1:0] held;
    scale_t             tab [TAB_N];

    always_comb begin
        if (ratio < RATIO_W'(RATIO_MIN))      eff = RATIO_W'(RATIO_MIN);
        else if (ratio > RATIO_W'(RATIO_MAX)) eff = RATIO_W'(RATIO_MAX);
        else                                  eff = ratio;
    end

    assign clear = !rst && (eff != held);

    always_ff @(posedge clk) begin
        if (rst) held <= RATIO_W'(RATIO_MIN);
        else     held <= eff;
    end

    for (genvar r = 0; r < TAB_N; r++) begin : g_tab
        localparam int RR = clamp_ratio(r);
        localparam int SH = shift_of(RR) + FRAC_W;
        localparam longint unsigned ML = mult_of(RR);
        assign tab[r] = '{shift: SHIFT_W'(SH), mult: MULT_W'(ML)};
    end

    assign scl = tab[held];

    // R4: the ratio in use never leaves the legal range
    p_ratio_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (held >= RATIO_W'(RATIO_MIN)) && (held <= RATIO_W'(RATIO_MAX)));
endmodule

// File: rtl/cic_channel.sv
module cic_channel
    import cic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce,
    input  logic    strobe,
    input  logic    clear,
    input  sample_t x,
    output acc_t    acc
);
    acc_t comb_in  [STAGES+1];
    acc_t integ_in [STAGES+1];
    acc_t integ_q  [STAGES];

    assign comb_in[0] = ACC_W'(x);

    for (genvar k = 0; k < STAGES; k++) begin : g_comb
        acc_t dly_r;
        assign comb_in[k+1] = comb_in[k] - dly_r;
        always_ff @(posedge clk) begin
            if (rst || clear) dly_r <= '0;
            else if (strobe)  dly_r <= comb_in[k];
        end
    end

    // zero-stuffing: comb result once per strobe, zeros otherwise
    assign integ_in[0] = strobe ? comb_in[STAGES] : '0;

    for (genvar k = 0; k < STAGES; k++) begin : g_integ
        acc_t sum_r;
        always_ff @(posedge clk) begin
            if (rst || clear) sum_r <= '0;
            else if (ce)      sum_r <= sum_r + integ_in[k];
        end
        assign integ_q[k]    = sum_r;
        assign integ_in[k+1] = sum_r;
    end

    assign acc = integ_q[STAGES-1];

    // R3: enabled cycles without a strobe feed zero into the first integrator
    p_zero_stuff_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && !strobe && !clear) |=> (integ_q[0] == $past(integ_q[0])));
    // R5: a ratio change empties the integrator chain
    p_clear_acc_r5: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));
    // R2: no enable, no change
    p_hold_acc_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce && !clear) |=> $stable(acc));
endmodule

// File: rtl/cic_scaler.sv
module cic_scaler
    import cic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce,
    input  logic    clear,
    input  acc_t    acc,
    input  scale_t  scl,
    output sample_t y
);
    localparam int PROD_W = ACC_W + MULT_W + 1;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = PROD_W'(-(2 ** (DATA_W - 1)));

    logic signed [PROD_W-1:0] a_ext, m_ext, prod, half, rounded, shifted;
    sample_t                  sat_v;

    always_comb begin
        a_ext   = PROD_W'(acc);
        m_ext   = $signed(PROD_W'({1'b0, scl.mult}));
        prod    = a_ext * m_ext;
        half    = PROD_W'(1) << (scl.shift - SHIFT_W'(1));
        rounded = prod + half;
        shifted = rounded >>> scl.shift;
        if (shifted > SAT_HI)      sat_v = SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO) sat_v = SAT_LO[DATA_W-1:0];
        else                       sat_v = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) y <= '0;
        else if (ce)      y <= sat_v;
    end

    // R3: a zero integrator sum always leaves zero at the output
    p_zero_maps_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && !clear && acc == '0) |=> (y == '0));
endmodule

// File: rtl/cic_interp.sv
module cic_interp
    import cic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hi_ce,
    input  logic               in_valid,
    input  logic [RATIO_W-1:0] ratio,
    input  sample_t            in_i,
    input  sample_t            in_q,
    output sample_t            out_i,
    output sample_t            out_q,
    output logic               out_valid
);
    logic    clear;
    logic    strobe;
    scale_t  scl;
    sample_t xin  [NUM_CH];
    sample_t yout [NUM_CH];
    acc_t    accs [NUM_CH];

    cic_ratio_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .ratio (ratio),
        .clear (clear),
        .scl   (scl)
    );

    assign strobe  = hi_ce && in_valid && !clear;
    assign xin[0]  = in_i;
    assign xin[1]  = in_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cic_channel u_chan (
            .clk    (clk),
            .rst    (rst),
            .ce     (hi_ce),
            .strobe (strobe),
            .clear  (clear),
            .x      (xin[c]),
            .acc    (accs[c])
        );
        cic_scaler u_scale (
            .clk   (clk),
            .rst   (rst),
            .ce    (hi_ce),
            .clear (clear),
            .acc   (accs[c]),
            .scl   (scl),
            .y     (yout[c])
        );
    end

    assign out_i = yout[0];
    assign out_q = yout[1];

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= hi_ce;
    end

    // R1: reset leaves quiet outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_i == '0 && out_q == '0));
    // R2: valid marks the cycle after each enabled cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        hi_ce |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !hi_ce |=> !out_valid);
    p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
        (!hi_ce && !clear) |=> ($stable(out_i) && $stable(out_q)));
    // R5: outputs read zero after a ratio change
    p_clear_out_r5: assert property (@(posedge clk) disable iff (rst)
        clear |=> (out_i == '0 && out_q == '0));
endmodule

// File: tb/cic_interp_tb.sv
`timescale 1ns/1ps
module cic_interp_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hi_ce = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  ratio = 6'd2;
    logic signed [11:0] in_i = '0, in_q = '0;
    logic signed [11:0] out_i, out_q;
    logic        out_valid;

    int total = 0;
    int bad = 0;
    int si, sq;
    logic sv;
    int buf_i [160];
    int buf_q [160];
    int buf_a [160];
    int nrec;

    always #4 clk = ~clk;

    cic_interp u_dut (
        .clk(clk), .rst(rst), .hi_ce(hi_ce), .in_valid(in_valid), .ratio(ratio),
        .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    localparam int NV = 12;
    localparam int VEC [NV][3] = '{
        '{2, 100, -100}, '{3, 2047, -2048}, '{4, -2048, 2047}, '{7, 1, -1},
        '{16, 0, 1234}, '{31, -777, 555}, '{63, 2047, -2048}, '{63, -1, 1},
        '{5, 1500, -3}, '{2, -2048, 2047}, '{12, 321, -1234}, '{50, 2000, -2000}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle; samples reflect the previous cycle's edge
    task automatic drive(input logic ce, input logic v, input int xi, input int xq);
        @(negedge clk);
        si = int'(out_i);
        sq = int'(out_q);
        sv = out_valid;
        hi_ce = ce;
        in_valid = v;
        in_i = 12'(xi);
        in_q = 12'(xq);
    endtask

    task automatic set_ratio(input int r);
        @(negedge clk);
        ratio = 6'(r);
        hi_ce = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic period(input int r, input int xi, input int xq);
        for (int k = 0; k < r; k++) drive(1'b1, k == 0, xi, xq);
    endtask

    task automatic impulse(input int r, input int amp);
        nrec = 4 * r + 12;
        for (int n = 0; n < nrec; n++) begin
            drive(1'b1, (n % r) == 0, (n == 0) ? amp : 0, 0);
            buf_i[n] = si;
            buf_q[n] = sq;
        end
    endtask

    task automatic analyse(input int r);
        int first = -1, last = -1, neg = 0, asym = 0, qnz = 0;
        for (int n = 0; n < nrec; n++) begin
            if (buf_i[n] != 0) begin
                if (first < 0) first = n;
                last = n;
            end
            if (buf_i[n] < 0) neg++;
            if (buf_q[n] != 0) qnz++;
        end
        check("R6 impulse span ok", (first >= 0 && (last - first + 1) <= 4 * r - 3) ? 1 : 0, 1);
        check("R6 impulse non-negative", neg, 0);
        if (first >= 0)
            for (int n = first; n <= last; n++)
                if (buf_i[n] != buf_i[last - (n - first)]) asym++;
        check("R6 impulse symmetric", asym, 0);
        check("R9 idle channel stays zero", qnz, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset with busy inputs
        hi_ce = 1'b1; in_valid = 1'b1; in_i = 12'sd500; in_q = -12'sd500;
        repeat (3) @(posedge clk);
        drive(1'b1, 1'b1, 500, -500);
        check("R1 out_i after reset", si, 0);
        check("R1 out_q after reset", sq, 0);
        check("R1 out_valid after reset", int'(sv), 0);
        @(negedge clk);
        rst = 1'b0;
        hi_ce = 1'b0;
        in_valid = 1'b0;

        // R3 / R9: vector table of ratios and constant inputs
        for (int e = 0; e < NV; e++) begin
            set_ratio(VEC[e][0]);
            repeat (8) period(VEC[e][0], VEC[e][1], VEC[e][2]);
            drive(1'b0, 1'b0, 0, 0);
            check($sformatf("R3 dc out_i ratio %0d", VEC[e][0]), si, VEC[e][1]);
            check($sformatf("R9 dc out_q ratio %0d", VEC[e][0]), sq, VEC[e][2]);
        end

        // R6: impulse shape at several ratios
        set_ratio(2);  impulse(2, 1000);  analyse(2);
        set_ratio(6);  impulse(6, 1000);  analyse(6);
        set_ratio(13); impulse(13, 1000); analyse(13);

        // R4: codes 1 and 0 behave like ratio 2
        set_ratio(5); drive(1'b0, 1'b0, 0, 0);
        set_ratio(2); impulse(2, 1500);
        for (int n = 0; n < nrec; n++) buf_a[n] = buf_i[n];
        set_ratio(5); drive(1'b0, 1'b0, 0, 0);
        set_ratio(1); impulse(2, 1500);
        begin
            int mism = 0;
            for (int n = 0; n < nrec; n++) if (buf_i[n] != buf_a[n]) mism++;
            check("R4 ratio code 1 matches 2", mism, 0);
        end
        set_ratio(5); drive(1'b0, 1'b0, 0, 0);
        set_ratio(0); impulse(2, 1500);
        begin
            int mism = 0;
            for (int n = 0; n < nrec; n++) if (buf_i[n] != buf_a[n]) mism++;
            check("R4 ratio code 0 matches 2", mism, 0);
        end

        // R7: monotone step response
        set_ratio(5);
        begin
            int prev = 0, drops = 0;
            for (int p = 0; p < 10; p++)
                for (int k = 0; k < 5; k++) begin
                    drive(1'b1, k == 0, 1800, 0);
                    if (si < prev) drops++;
                    prev = si;
                end
            drive(1'b0, 1'b0, 0, 0);
            if (si < prev) drops++;
            check("R7 step never decreases", drops, 0);
            check("R7 step final value", si, 1800);
        end

        // R2: hold while the enable is low
        set_ratio(4);
        period(4, 1500, -900);
        period(4, 1500, -900);
        begin
            int s1;
            drive(1'b0, 1'b0, 1500, -900);
            s1 = si;
            check("R2 valid after enabled cycle", int'(sv), 1);
            drive(1'b0, 1'b0, 1500, -900);
            check("R2 valid low after idle cycle", int'(sv), 0);
            drive(1'b0, 1'b0, 1500, -900);
            drive(1'b1, 1'b1, 1500, -900);
            check("R2 output held while idle", si, s1);
            check("R2 valid low before resume", int'(sv), 0);
            drive(1'b0, 1'b0, 0, 0);
            check("R2 valid after resume", int'(sv), 1);
        end

        // R5: ratio change clears state and drops the coincident strobe
        set_ratio(4);
        repeat (8) period(4, 1500, 1500);
        @(negedge clk);
        ratio = 6'd9;
        hi_ce = 1'b1; in_valid = 1'b1; in_i = 12'sd2000; in_q = 12'sd2000;
        begin
            int nz = 0;
            for (int n = 0; n < 40; n++) begin
                drive(1'b1, (n % 9) == 8, 0, 0);
                if (si != 0 || sq != 0) nz++;
            end
            check("R5 outputs zero after ratio change", nz, 0);
        end

        // R8: strobe without enable injects nothing
        set_ratio(6);
        drive(1'b0, 1'b1, 1500, 1500);
        begin
            int nz = 0;
            for (int n = 0; n < 36; n++) begin
                drive(1'b1, 1'b0, 0, 0);
                if (si != 0 || sq != 0) nz++;
            end
            check("R8 unenabled strobe ignored", nz, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule